// File: doc/BRIEF.md
# Dithered Quarter-Wave Sine/Cosine Oscillator

This block is a numerically controlled oscillator that produces a pair of signed quadrature samples, one cosine and one sine, per enabled clock. A phase register adds a frequency word on each enabled cycle and wraps modulo 2^PHASE_W. The output frequency is therefore freqWord × Fclk / 2^PHASE_W, and the frequency step is Fclk / 2^PHASE_W. The phase is cut down to ADDR_W address bits, which name one of 2^ADDR_W points on the circle. Only one quarter of a sine period is stored, as a table computed at elaboration. The other three quarters come from reading that table forwards or backwards and negating the result.

To break up the periodic error caused by discarding the low phase bits, a pseudo-random value can be added to the full-width phase ahead of the cut. This value comes from a free-running shift register and never exceeds the discarded field. A dithered address therefore differs from the plain one by at most one step. The table read and the sign stage are both registered, and a valid flag travels with each sample.

Top module: `nco_sine_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the phase register, both outputs and outValid to zero, and loads the noise register with 16'hACE1.
- R2: On every rising edge with enable high, the phase register becomes (phase + freqWord) mod 2^PHASE_W. A new freqWord changes the very next phase step, with no settling time.
- R3: While enable is low, the phase register and noise register hold. No new sample is flagged valid, and cosOut and sinOut keep their values.
- R4: The sample derived from the phase held during an enabled cycle appears on cosOut and sinOut, with outValid high, after exactly two rising edges. outValid is high only in that case.
- R5: The table address is the top ADDR_W bits of (phase + D) mod 2^PHASE_W. D is zero when ditherEn is low. When ditherEn is high, D is the noise register value limited to its low PHASE_W−ADDR_W bits.
- R6: For address p, sinOut equals A·sin(2π(p+0.5)/2^ADDR_W) rounded half away from zero, with A = 2^(SAMP_W−1)−1. Only 2^(ADDR_W−2) positive magnitudes are stored. The top two address bits select the quadrant: 0 reads forward, 1 reads backward, 2 reads forward and negates, 3 reads backward and negates.
- R7: For address p, cosOut equals A·cos(2π(p+0.5)/2^ADDR_W) rounded half away from zero. It uses quadrant reads backward, forward negated, backward negated and forward.
- R8: Neither output ever takes the most negative code −2^(SAMP_W−1).
- R9: The noise register is 16 bits wide and shifts left on every enabled cycle, whether or not ditherEn is high. The new bit 0 is bit15^bit13^bit12^bit10, and the value added to the phase is the register's value before that shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance the phase and issue a sample this cycle |
| freqWord | input | PHASE_W | Phase increment per enabled cycle (two's complement) |
| ditherEn | input | 1 | Add noise to the phase ahead of truncation |
| cosOut | output | SAMP_W | Signed cosine sample |
| sinOut | output | SAMP_W | Signed sine sample |
| outValid | output | 1 | cosOut and sinOut carry a new sample |

## Verification
The assertions check several rules on every cycle: the phase step and phase hold under enable, the two-cycle relation between enable and outValid, output stability while no sample is valid, and the ban on the most negative code. The waveform values themselves can only be shown by the bench's scenarios. These are quadrant crossings, phase wraparound in both directions, word changes on consecutive cycles, gapped enables, and dither sequences. In each of them a behavioural model built from the sine and cosine formulas and the noise polynomial predicts every sample.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam int NOISE_W = 16;
  localparam logic [NOISE_W-1:0] NOISE_SEED = 16'hACE1;

  typedef struct packed {
    logic stepPhase;
    logic loadTable;
    logic loadOut;
    logic ditherOn;
  } nco_strobe_t;

  function automatic logic [NOISE_W-1:0] noiseNext(input logic [NOISE_W-1:0] cur);
    return {cur[NOISE_W-2:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
  endfunction

endpackage

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
  parameter int IDX_W  = 6,
  parameter int SAMP_W = 16
) (
  input  logic [IDX_W-1:0]  idxA,
  input  logic [IDX_W-1:0]  idxB,
  output logic [SAMP_W-1:0] magA,
  output logic [SAMP_W-1:0] magB
);
  localparam int  DEPTH   = 1 << IDX_W;
  localparam real HALF_PI = 1.57079632679489661923;
  localparam real AMP     = real'((2 ** (SAMP_W - 1)) - 1);

  logic [SAMP_W-1:0] quarterTbl [DEPTH];

  // Each entry sits half a step off the axis so that backward reads
  // through the complemented index mirror the curve exactly.
  for (genvar k = 0; k < DEPTH; k++) begin : gEntry
    localparam real ANG = (real'(k) + 0.5) * HALF_PI / real'(DEPTH);
    localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
    assign quarterTbl[k] = SAMP_W'(VAL);
  end

  assign magA = quarterTbl[idxA];
  assign magB = quarterTbl[idxB];

endmodule

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               ditherEn,
  output nco_strobe_t        strobe,
  output logic [NOISE_W-1:0] noiseBits,
  output logic               outValid
);
  logic tableValid;
  logic [NOISE_W-1:0] noiseReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      tableValid <= 1'b0;
      outValid   <= 1'b0;
      noiseReg   <= NOISE_SEED;
    end else begin
      tableValid <= enable;
      outValid   <= tableValid;
      if (enable) noiseReg <= noiseNext(noiseReg);
    end
  end

  always_comb begin
    strobe.stepPhase = enable;
    strobe.loadTable = enable;
    strobe.loadOut   = tableValid;
    strobe.ditherOn  = ditherEn;
  end

  assign noiseBits = noiseReg;

endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 8,
  parameter int SAMP_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  nco_strobe_t              strobe,
  input  logic [PHASE_W-1:0]       freqWord,
  input  logic [NOISE_W-1:0]       noiseBits,
  output logic signed [SAMP_W-1:0] cosOut,
  output logic signed [SAMP_W-1:0] sinOut
);
  localparam int TRUNC_W = PHASE_W - ADDR_W;
  localparam int IDX_W   = ADDR_W - 2;

  logic [PHASE_W-1:0] phaseAcc;
  logic [PHASE_W-1:0] ditherVal;
  logic [PHASE_W-1:0] ditheredPhase;
  logic [ADDR_W-1:0]  circleAddr;
  logic [1:0]         quadrant;
  logic [IDX_W-1:0]   quarterIdx;
  logic [IDX_W-1:0]   sinIdx;
  logic [IDX_W-1:0]   cosIdx;
  logic [SAMP_W-1:0]  sinMagRd;
  logic [SAMP_W-1:0]  cosMagRd;
  logic [SAMP_W-1:0]  sinMag;
  logic [SAMP_W-1:0]  cosMag;
  logic               sinNeg;
  logic               cosNeg;

  // Noise confined to the discarded field
  if (TRUNC_W >= NOISE_W) begin : gWideTrunc
    assign ditherVal = PHASE_W'(noiseBits);
  end else begin : gNarrowTrunc
    assign ditherVal = PHASE_W'(noiseBits[TRUNC_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) phaseAcc <= '0;
    else if (strobe.stepPhase) phaseAcc <= phaseAcc + freqWord;
  end

  always_comb begin
    ditheredPhase = phaseAcc + (strobe.ditherOn ? ditherVal : '0);
    circleAddr    = ditheredPhase[PHASE_W-1 -: ADDR_W];
    quadrant      = circleAddr[ADDR_W-1 -: 2];
    quarterIdx    = circleAddr[IDX_W-1:0];
    sinIdx        = quadrant[0] ? ~quarterIdx : quarterIdx;
    cosIdx        = quadrant[0] ? quarterIdx : ~quarterIdx;
  end

  nco_quarter_rom #(
    .IDX_W  (IDX_W),
    .SAMP_W (SAMP_W)
  ) u_rom (
    .idxA (sinIdx),
    .idxB (cosIdx),
    .magA (sinMagRd),
    .magB (cosMagRd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sinMag <= '0;
      cosMag <= '0;
      sinNeg <= 1'b0;
      cosNeg <= 1'b0;
    end else if (strobe.loadTable) begin
      sinMag <= sinMagRd;
      cosMag <= cosMagRd;
      sinNeg <= quadrant[1];
      cosNeg <= quadrant[1] ^ quadrant[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sinOut <= '0;
      cosOut <= '0;
    end else if (strobe.loadOut) begin
      sinOut <= sinNeg ? -$signed(sinMag) : $signed(sinMag);
      cosOut <= cosNeg ? -$signed(cosMag) : $signed(cosMag);
    end
  end

endmodule

// File: rtl/nco_sine_gen.sv
module nco_sine_gen
  import nco_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 8,
  parameter int SAMP_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic [PHASE_W-1:0]       freqWord,
  input  logic                     ditherEn,
  output logic signed [SAMP_W-1:0] cosOut,
  output logic signed [SAMP_W-1:0] sinOut,
  output logic                     outValid
);
  nco_strobe_t        strobe;
  logic [NOISE_W-1:0] noiseBits;

  nco_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .ditherEn  (ditherEn),
    .strobe    (strobe),
    .noiseBits (noiseBits),
    .outValid  (outValid)
  );

  nco_datapath #(
    .PHASE_W (PHASE_W),
    .ADDR_W  (ADDR_W),
    .SAMP_W  (SAMP_W)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .freqWord  (freqWord),
    .noiseBits (noiseBits),
    .cosOut    (cosOut),
    .sinOut    (sinOut)
  );

endmodule

// File: rtl/nco_sine_gen_chk.sv
module nco_sine_gen_chk #(
  parameter int PHASE_W = 24,
  parameter int SAMP_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     enable,
  input logic [PHASE_W-1:0]       freqWord,
  input logic                     outValid,
  input logic signed [SAMP_W-1:0] cosOut,
  input logic signed [SAMP_W-1:0] sinOut,
  input logic [PHASE_W-1:0]       phaseNow
);
  localparam logic [SAMP_W-1:0] MIN_CODE = {1'b1, {(SAMP_W-1){1'b0}}};

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(enable)) |-> phaseNow == $past(phaseNow) + $past(freqWord)); // R2

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(enable)) |-> $stable(phaseNow)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !outValid) |-> ($stable(cosOut) && $stable(sinOut))); // R3

  AST_VALID_ONLY_AFTER_ENABLE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(enable, 2)); // R4

  AST_VALID_AFTER_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(enable, 2)) |-> outValid); // R4

  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (rst)
    (cosOut != MIN_CODE) && (sinOut != MIN_CODE)); // R8

endmodule

bind nco_sine_gen nco_sine_gen_chk #(
  .PHASE_W (PHASE_W),
  .SAMP_W  (SAMP_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .freqWord (freqWord),
  .outValid (outValid),
  .cosOut   (cosOut),
  .sinOut   (sinOut),
  .phaseNow (u_data.phaseAcc)
);

// File: tb/nco_sine_gen_test.sv
module nco_sine_gen_test;
  localparam int  PW   = 24;
  localparam int  AW   = 8;
  localparam int  SW   = 16;
  localparam real TWO_PI = 6.28318530717958647692;
  localparam real AMPL = 32767.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [PW-1:0] freqWord = '0;
  logic ditherEn = 1'b0;
  logic signed [SW-1:0] cosOut;
  logic signed [SW-1:0] sinOut;
  logic outValid;

  int checks = 0;
  int errors = 0;
  string scen = "R1";
  bit started = 0;
  bit done = 0;

  // reference state
  longint mAcc;
  logic [15:0] mLfsr;
  bit mV1, mVo;
  int mC1, mS1, mCo, mSo;

  always #10 clk = ~clk;

  nco_sine_gen uut (
    .clk(clk), .rst(rst), .enable(enable), .freqWord(freqWord),
    .ditherEn(ditherEn), .cosOut(cosOut), .sinOut(sinOut), .outValid(outValid)
  );

  function automatic int roundAway(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int sinRef(input longint p);   // R6
    return roundAway(AMPL * $sin(TWO_PI * (real'(p) + 0.5) / 256.0));
  endfunction

  function automatic int cosRef(input longint p);   // R7
    return roundAway(AMPL * $cos(TWO_PI * (real'(p) + 0.5) / 256.0));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mAcc = 0; mLfsr = 16'hACE1; mV1 = 0; mVo = 0;
      mC1 = 0; mS1 = 0; mCo = 0; mSo = 0; started = 1;
    end else begin
      longint addr;
      if (mV1) begin mCo = mC1; mSo = mS1; end
      mVo = mV1;
      if (enable) begin
        addr = ((mAcc + (ditherEn ? longint'(mLfsr) : 0)) % (64'd1 << PW)) >> (PW - AW); // R5 R9
        mC1 = cosRef(addr);
        mS1 = sinRef(addr);
        mV1 = 1;
        mAcc = (mAcc + longint'(freqWord)) % (64'd1 << PW);                            // R2
        mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};          // R9
      end else begin
        mV1 = 0;                                                                        // R3
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (outValid !== mVo || int'(cosOut) != mCo || int'(sinOut) != mSo) begin
        errors++;
        $display("FAIL %s R4 cos/sin/valid act=%0d/%0d/%0b exp=%0d/%0d/%0b",
                 scen, cosOut, sinOut, outValid, mCo, mSo, mVo);
      end
      checks++;
      if (cosOut == -16'sd32768 || sinOut == -16'sd32768) begin
        errors++;
        $display("FAIL R8 min code act=%0d/%0d exp=not -32768", cosOut, sinOut);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cycles(3);
    checks++;
    if (outValid !== 1'b0 || cosOut !== '0 || sinOut !== '0) begin
      errors++;
      $display("FAIL R1 reset state act=%0d/%0d/%0b exp=0/0/0", cosOut, sinOut, outValid);
    end
    rst = 0;

    scen = "R2 R5 R6 R7 one-step-per-sample";
    enable = 1; freqWord = 24'h010000;
    cycles(300);

    scen = "R2 wrap large word";
    freqWord = 24'h9A3C71;
    cycles(200);

    scen = "R2 backward word";
    freqWord = 24'hFF0000;
    cycles(150);

    scen = "R2 word changes every cycle";
    for (int i = 0; i < 60; i++) begin
      freqWord = PW'(i * 24'h03A517 + 24'h001234);
      cycles(1);
    end

    scen = "R3 gapped enable";
    freqWord = 24'h0A1B2C;
    for (int i = 0; i < 90; i++) begin
      enable = (i % 3) != 0;
      cycles(1);
    end
    enable = 0;
    cycles(5);

    scen = "R5 R9 dither on";
    enable = 1; ditherEn = 1; freqWord = 24'h0930A7;
    cycles(400);

    scen = "R5 R9 dither with zero word";
    freqWord = 24'h000000;
    cycles(100);

    scen = "R9 dither toggled with gaps";
    freqWord = 24'h123457;
    for (int i = 0; i < 120; i++) begin
      ditherEn = (i % 5) < 2;
      enable = (i % 7) != 3;
      cycles(1);
    end

    scen = "R1 mid-run reset";
    rst = 1;
    cycles(1);
    checks++;
    if (outValid !== 1'b0 || cosOut !== '0 || sinOut !== '0) begin
      errors++;
      $display("FAIL R1 mid reset act=%0d/%0d/%0b exp=0/0/0", cosOut, sinOut, outValid);
    end
    rst = 0; enable = 1; ditherEn = 0; freqWord = 24'h400000;
    scen = "R6 R7 quadrant corners";
    cycles(40);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R4 act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule